// File: doc/BRIEF.md
# Configurable Bidirectional Port with Option Register

This block is one byte-wide general purpose I/O port. Software programs three registers over a simple byte register bus: an output latch, a direction register and an option register. Per pin, the block works out the value to put on the pad, whether the pad driver is on, and whether the weak pull-up is on. It also reports which pins may raise an interrupt, for use by a separate edge or level detector.

The option bit means different things depending on direction. On an input pin it selects between a floating input and a pulled-up input that can raise an interrupt. On an output pin it selects between open-drain drive, where only a low level is driven, and push-pull drive. A peripheral can take over a pin through its alternate-function enable. Its output then replaces the latch and the pad driver is switched on. Pins that a product variant does not bond out are marked by a parameter mask. Those pins read as 1 in every register, never drive and never pull. Reads are combinational, so data comes back in the same cycle as the address.

Top module: `gpio_port_opt`

## Requirements
- R1: After reset, every implemented pin is an input (direction bits 0), the latch bits are 0 and the option bits take the OPT_RESET parameter value. No implemented pin drives, pulls up or flags an interrupt.
- R2: Direction bit value 1 makes a pin an output and value 0 makes it an input. An input pin without alternate function has pad_oe 0.
- R3: A write to address 0 (data) updates the latch on every implemented pin, including pins that are inputs. The stored value shows once the pin is made an output.
- R4: A read of address 0 returns the latch bit for output pins. For input pins it returns the pad level after a two-flop synchroniser: a pad change shows in the read after the second rising clock edge, and not before it.
- R5: On an input pin, option bit 0 gives pad_pu 0 and pin_irq_en 0 (floating). Option bit 1 gives pad_pu 1 and pin_irq_en 1.
- R6: On an output pin, option bit 0 gives open-drain drive: pad_oe equals the inverted latch bit and pad_out is 0. Option bit 1 gives push-pull drive: pad_oe is 1 and pad_out equals the latch bit.
- R7: On an implemented pin with alt_en 1, pad_oe is 1 and pad_out equals alt_out, whatever the latch, direction and option bits hold.
- R8: Pins whose IMPL_MASK bit is 0 read as 1 at addresses 0, 1 and 2, both after reset and after any write. They always have pad_oe, pad_out, pad_pu and pin_irq_en at 0, even while alt_en is set.
- R9: pin_irq_en is 0 on every pin whose direction bit is 1.
- R10: bus_rdata is combinational in bus_addr. Address 1 returns direction, address 2 returns option, and address 3 returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 option, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as the address |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Value driven onto each pad |
| pad_oe | output | 8 | Pad driver enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |
| alt_en | input | 8 | Alternate-function output enable from peripherals |
| alt_out | input | 8 | Alternate-function output value from peripherals |
| pin_irq_en | output | 8 | Pin may raise an interrupt, to the external detector |

## Verification
The assertions take for granted that bus_addr, bus_wr and the alternate-function inputs are stable around each rising edge. They also take for granted that pad_in reaches the block only through its synchroniser. The stimulus meets this by changing every input on the falling clock edge. Register writes last exactly one rising edge, and pad levels are held for at least two edges before an input read is compared. The synchroniser checks count the cycles since reset, so the flop values loaded during reset are not compared against pad levels from before reset.

// File: rtl/gpio_opt_pkg.sv
package gpio_opt_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_OPT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic out;
    logic oe;
    logic pu;
    logic irq;
  } pin_drive_t;

  // Per-pin drive decision from configuration and peripheral override.
  function automatic pin_drive_t pin_drive(input logic present, input logic dir,
                                           input logic opt, input logic latch,
                                           input logic alt_en, input logic alt_out);
    pin_drive_t d;
    d = '0;
    if (present) begin
      if (alt_en) begin
        d.out = alt_out;
        d.oe  = 1'b1;
      end else if (dir) begin
        d.out = opt ? latch : 1'b0;
        d.oe  = opt ? 1'b1 : ~latch;
      end
      d.pu  = ~dir & opt;
      d.irq = ~dir & opt;
    end
    return d;
  endfunction

  // Data read: latch for outputs, synchronised pad for inputs.
  function automatic logic data_view(input logic dir, input logic latch, input logic pin);
    return dir ? latch : pin;
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_opt_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1,
  parameter logic [W-1:0] OPT_RESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_v,
  output logic [W-1:0] dir_v,
  output logic [W-1:0] opt_v
);
  localparam logic [W-1:0] ABSENT = ~IMPL_MASK;

  logic [W-1:0] latch_q, dir_q, opt_q;
  logic         data_wr_ev;

  assign data_wr_ev = wr_en && (wr_sel == REG_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      opt_q   <= OPT_RESET;
    end else if (wr_en) begin
      case (wr_sel)
        REG_DATA: latch_q <= wdata;
        REG_DIR:  dir_q   <= wdata;
        REG_OPT:  opt_q   <= wdata;
        default:  ;
      endcase
    end
  end

  assign latch_v = latch_q | ABSENT;
  assign dir_v   = dir_q   | ABSENT;
  assign opt_v   = opt_q   | ABSENT;

  // R3: latch follows a data write regardless of direction
  assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev |=> (latch_v == ($past(wdata) | ABSENT)));

  // R3: no change to latch without a data write
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr_ev |=> $stable(latch_v));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];
  logic         warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg[0] <= '0;
      warm   <= 1'b0;
    end else begin
      stg[0] <= async_in;
      warm   <= 1'b1;
    end
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end

    // R4: each stage is one clock behind the previous one
    assert_stage_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (stg[k] == $past(stg[k-1])));
  end

  assign sync_out = stg[STAGES-1];

  // R4: first stage captures the pad one clock later
  assert_first_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (stg[0] == $past(async_in)));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_opt_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic opt,
  input  logic latch,
  input  logic alt_en,
  input  logic alt_out,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_pu,
  output logic irq_en
);
  pin_drive_t drv;

  always_comb drv = pin_drive(PRESENT, dir, opt, latch, alt_en, alt_out);

  assign pad_out = drv.out;
  assign pad_oe  = drv.oe;
  assign pad_pu  = drv.pu;
  assign irq_en  = drv.irq;

  // R9: interrupt capability never coexists with output direction
  assert_irq_off_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dir |-> !irq_en);

  // R6: open-drain only ever drives low
  assert_od_low_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && !opt && !alt_en && pad_oe) |-> !pad_out);

  // R7: alternate function forces the driver on for a present pin
  assert_alt_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (PRESENT && alt_en) |-> (pad_oe && (pad_out == alt_out)));

  // R2: plain input never drives
  assert_input_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir && !alt_en) |-> !pad_oe);

  // R8: absent pin is inert
  assert_absent_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !PRESENT |-> !(pad_oe || pad_out || pad_pu || irq_en));

endmodule

// File: rtl/gpio_port_opt.sv
module gpio_port_opt
  import gpio_opt_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'h3F,
  parameter logic [WIDTH-1:0] OPT_RESET = 8'h00,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_out,
  output logic [WIDTH-1:0] pin_irq_en
);
  localparam logic [WIDTH-1:0] ABSENT = ~IMPL_MASK;

  reg_sel_e         sel;
  logic             wr_ev;
  logic [WIDTH-1:0] latch_v, dir_v, opt_v, pin_sync, data_rd;

  assign sel   = reg_sel_e'(bus_addr);
  assign wr_ev = bus_sel && bus_wr;

  gpio_regs #(.W(WIDTH), .IMPL_MASK(IMPL_MASK), .OPT_RESET(OPT_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ev), .wr_sel(sel), .wdata(bus_wdata),
    .latch_v(latch_v), .dir_v(dir_v), .opt_v(opt_v)
  );

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_ctrl #(.PRESENT(IMPL_MASK[i])) u_pin (
      .clk(clk), .rst_n(rst_n), .dir(dir_v[i]), .opt(opt_v[i]), .latch(latch_v[i]),
      .alt_en(alt_en[i]), .alt_out(alt_out[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i]), .pad_pu(pad_pu[i]), .irq_en(pin_irq_en[i])
    );
    assign data_rd[i] = data_view(dir_v[i], latch_v[i], pin_sync[i]) | ABSENT[i];
  end

  always_comb begin
    case (sel)
      REG_DATA: bus_rdata = data_rd;
      REG_DIR:  bus_rdata = dir_v;
      REG_OPT:  bus_rdata = opt_v;
      default:  bus_rdata = '0;
    endcase
  end

  // R8: absent pins read as 1 at every mapped address
  assert_absent_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_NONE) |-> ((bus_rdata & ABSENT) == ABSENT));

  // R10: unmapped address reads zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_NONE) |-> (bus_rdata == '0));

  // R4: output pins read back the latch
  assert_out_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_DATA) |-> ((bus_rdata & dir_v) == (latch_v & dir_v)));

endmodule

// File: tb/sim_gpio_port_opt.sv
`timescale 1ns/1ps
module sim_gpio_port_opt;
  localparam logic [7:0] MASK = 8'h3F;
  localparam logic [7:0] ABS  = 8'hC0;

  logic       clk = 0, rst_n = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pad_in = 0, pad_out, pad_oe, pad_pu, alt_en = 0, alt_out = 0, pin_irq_en;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port_opt u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .alt_en(alt_en), .alt_out(alt_out),
    .pin_irq_en(pin_irq_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 data reset", v, ABS);
    rd(2'd1, v); chk("R1 dir reset", v, ABS);
    rd(2'd2, v); chk("R1 opt reset", v, ABS);
    chk("R1 oe reset", pad_oe, 8'h00);
    chk("R1 pu reset", pad_pu, 8'h00);
    chk("R1 irq reset", pin_irq_en, 8'h00);
  endtask

  task automatic t_latch_on_input();
    logic [7:0] v;
    wr(2'd0, 8'h5A);
    rd(2'd0, v); chk("R3 input pins read pad", v, ABS);
    chk("R2 input no drive", pad_oe, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R3 latch kept while input", v, 8'hDA);
    chk("R6 open-drain oe", pad_oe, 8'h25);
    chk("R6 open-drain out", pad_out, 8'h00);
  endtask

  task automatic t_output_modes();
    wr(2'd2, 8'hFF);
    chk("R6 push-pull oe", pad_oe, 8'h3F);
    chk("R6 push-pull out", pad_out, 8'h1A);
    chk("R9 irq off on outputs", pin_irq_en, 8'h00);
    chk("R5 no pull on outputs", pad_pu, 8'h00);
  endtask

  task automatic t_pin_read();
    logic [7:0] v;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h03);
    @(negedge clk); pad_in = 8'hF5;
    rd(2'd0, v); chk("R4 no edge yet", v, 8'hC3);
    @(negedge clk);
    rd(2'd0, v); chk("R4 one edge", v, 8'hC3);
    @(negedge clk);
    rd(2'd0, v); chk("R4 two edges", v, 8'hF3);
    @(negedge clk); pad_in = 8'h00;
    @(negedge clk); @(negedge clk);
    rd(2'd0, v); chk("R4 pad low again", v, 8'hC3);
  endtask

  task automatic t_input_options();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h0C);
    chk("R5 pull-up", pad_pu, 8'h0C);
    chk("R5 irq enable", pin_irq_en, 8'h0C);
    chk("R2 inputs quiet", pad_oe, 8'h00);
    wr(2'd1, 8'h04);
    chk("R9 irq drops on output", pin_irq_en, 8'h08);
  endtask

  task automatic t_alt();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    @(negedge clk); alt_en = 8'h21; alt_out = 8'h01;
    #0.5;
    chk("R7 alt oe", pad_oe, 8'h21);
    chk("R7 alt out", pad_out, 8'h01);
    @(negedge clk); alt_en = 8'hC0; alt_out = 8'hC0;
    #0.5;
    chk("R8 absent alt oe", pad_oe, 8'h00);
    chk("R8 absent alt out", pad_out, 8'h00);
    @(negedge clk); alt_en = 0; alt_out = 0;
  endtask

  task automatic t_unimpl_and_addr();
    logic [7:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    rd(2'd0, v); chk("R8 data absent bits", v, ABS);
    rd(2'd1, v); chk("R8 dir absent bits", v, ABS);
    rd(2'd2, v); chk("R8 opt absent bits", v, ABS);
    wr(2'd2, 8'h33);
    rd(2'd2, v); chk("R10 opt readback", v, 8'hF3);
    rd(2'd3, v); chk("R10 unmapped", v, 8'h00);
    wr(2'd1, 8'h12);
    rd(2'd1, v); chk("R10 dir readback", v, 8'hD2);
    chk("R8 absent pull", pad_pu & ~MASK, 8'h00);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch_on_input();
    t_output_modes();
    t_pin_read();
    t_input_options();
    t_alt();
    t_unimpl_and_addr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule